// File: doc/BRIEF.md
# OUT Endpoint Shutdown Sequencer

This block holds the device-side control state that lets firmware take a USB OUT endpoint out of service without losing or splitting a packet. Firmware first raises a global OUT NAK request. The block lets any packet already being received finish. It then reports through a sticky interrupt that the global NAK is in force. From then on every incoming OUT data packet, on any endpoint, is answered with NAK and nothing is written to the receive FIFO.

With the global NAK in force, firmware asks for an endpoint to be disabled by setting that endpoint's disable-request and set-NAK bits together. The block completes the teardown, clears the endpoint's enable and disable-request bits, and raises a sticky per-endpoint "disabled" interrupt. When firmware drops the global NAK request, endpoints that are still enabled accept data again.

Packet traffic is modelled by a start pulse, which carries the endpoint number, and an end pulse. The block answers each start pulse one cycle later with an ACK/NAK decision and a FIFO-write strobe.

Top module: `out_ep_disable_ctrl`

## Requirements
- R1: After reset, every endpoint enable, disable-request and NAK bit is 0. The global NAK request and effective flags are 0, all interrupts are 0, and no response is valid.
- R2: When a global NAK is requested while an accepted packet is in flight, `gnak_eff_o` stays 0 until the packet ends. It rises at the second clock edge after the edge that registers the `pkt_end_i` pulse.
- R3: When a global NAK is requested with no packet in flight, `gnak_eff_o` rises at the second clock edge after the edge that samples the `gnak_set_i` pulse.
- R4: `irq_gnak_o` is set when `gnak_eff_o` rises and stays set until a `irq_gnak_clr_i` pulse clears it. If a set and a clear fall in the same cycle, the set wins.
- R5: While the global NAK is requested or effective, every `pkt_start_i` is answered with `resp_nak_o`=1 and `fifo_wr_o`=0. In the response encoding, 1 means NAK and 0 means ACK.
- R6: A disable request on an enabled endpoint stays pending, with the enable bit held, while the global NAK is not effective. Once the global NAK is effective, the next clock edge clears that endpoint's enable and disable-request bits and sets its `irq_epdis_o` bit.
- R7: A disable request on an endpoint that is not enabled completes at the clock edge that samples it. The endpoint's `irq_epdis_o` bit is set and its disable-request bit is never seen as 1.
- R8: `ep_snak_i` sets and `ep_cnak_i` clears an endpoint's NAK bit. A packet start is accepted (`resp_nak_o`=0, `fifo_wr_o`=1) only if the endpoint is enabled and its NAK bit is 0. Otherwise it is NAKed. The response appears one cycle after the start pulse.
- R9: The edge that samples a `gnak_clr_i` pulse drops `gnak_eff_o`. After that, packets to endpoints that are enabled and not NAKed are accepted, and packets to disabled endpoints are still NAKed.
- R10: Each `irq_epdis_o` bit is cleared by a 1 on the matching `irq_epdis_clr_i` bit. If a set and a clear of the same bit fall in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gnak_set_i | input | 1 | Pulse: request global OUT NAK |
| gnak_clr_i | input | 1 | Pulse: withdraw global OUT NAK |
| ep_ena_set_i | input | NUM_EP | Per-endpoint pulse: enable endpoint |
| ep_dis_set_i | input | NUM_EP | Per-endpoint pulse: request disable |
| ep_snak_i | input | NUM_EP | Per-endpoint pulse: set endpoint NAK |
| ep_cnak_i | input | NUM_EP | Per-endpoint pulse: clear endpoint NAK |
| irq_gnak_clr_i | input | 1 | Write-one-to-clear for the global NAK interrupt |
| irq_epdis_clr_i | input | NUM_EP | Write-one-to-clear for the endpoint-disabled interrupts |
| pkt_start_i | input | 1 | Pulse: OUT data packet begins |
| pkt_ep_i | input | EPW | Endpoint number of the starting packet |
| pkt_end_i | input | 1 | Pulse: accepted packet has ended |
| gnak_req_o | output | 1 | Global NAK request bit |
| gnak_eff_o | output | 1 | Global NAK in force |
| irq_gnak_o | output | 1 | Sticky global-NAK-effective interrupt |
| ep_ena_o | output | NUM_EP | Endpoint enable bits |
| ep_dis_o | output | NUM_EP | Endpoint disable-request bits |
| ep_nak_o | output | NUM_EP | Endpoint NAK bits |
| irq_epdis_o | output | NUM_EP | Sticky endpoint-disabled interrupts |
| resp_valid_o | output | 1 | Response to the previous start pulse is valid |
| resp_nak_o | output | 1 | 1 = NAK, 0 = ACK |
| fifo_wr_o | output | 1 | Packet accepted into the receive FIFO |

## Verification
Two pairs of events can land on the same clock edge: an interrupt being raised and the firmware's write-one-to-clear of the same bit. The bench provokes the first pair by pulsing `irq_gnak_clr_i` in exactly the cycle in which the global NAK takes effect. It provokes the second by pulsing an endpoint's clear bit together with a disable request on that idle endpoint. In both cases the interrupt must read 1 afterwards, and a lone clear must then bring it to 0. Separately, a packet end and a pending global NAK are sequenced so that the cycle in which the NAK becomes effective is checked exactly.

// File: rtl/out_ep_pkg.sv
package out_ep_pkg;

    typedef struct packed {
        logic ena;
        logic dis;
        logic nak;
        logic irq;
    } ep_state_t;

    typedef struct packed {
        logic req;
        logic eff;
        logic irq;
    } gnak_state_t;

    typedef struct packed {
        logic in_pkt;
        logic resp_valid;
        logic resp_nak;
        logic fifo_wr;
    } rx_state_t;

endpackage

// File: rtl/gnak_ctrl.sv
module gnak_ctrl
    import out_ep_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic irq_clr_i,
    input  logic in_pkt_i,
    output logic req_o,
    output logic eff_o,
    output logic irq_o
);

    gnak_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set_i)      st_d.req = 1'b1;
        if (clr_i)      st_d.req = 1'b0;
        // takes effect only once no packet is in flight
        st_d.eff = st_q.req && !clr_i && (st_q.eff || !in_pkt_i);
        if (irq_clr_i)  st_d.irq = 1'b0;
        if (st_d.eff && !st_q.eff) st_d.irq = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_o = st_q.req;
    assign eff_o = st_q.eff;
    assign irq_o = st_q.irq;

    assert_eff_no_pkt_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.eff |-> !in_pkt_i);
    assert_eff_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.eff) |-> $past(st_q.req));
    assert_irq_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.irq && !irq_clr_i) |=> st_q.irq);
    assert_irq_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.eff) |-> st_q.irq);

endmodule

// File: rtl/ep_slot.sv
module ep_slot
    import out_ep_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ena_set_i,
    input  logic dis_set_i,
    input  logic snak_i,
    input  logic cnak_i,
    input  logic irq_clr_i,
    input  logic gnak_eff_i,
    output logic ena_o,
    output logic dis_o,
    output logic nak_o,
    output logic irq_o
);

    ep_state_t st_d, st_q;
    logic      done;

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        if (ena_set_i) st_d.ena = 1'b1;
        if (snak_i)    st_d.nak = 1'b1;
        if (cnak_i)    st_d.nak = 1'b0;
        if (irq_clr_i) st_d.irq = 1'b0;
        if (st_q.dis && gnak_eff_i) begin
            done = 1'b1;
        end else if (dis_set_i && !st_q.ena) begin
            done = 1'b1;              // idle endpoint: nothing to tear down
        end else if (dis_set_i) begin
            st_d.dis = 1'b1;
        end
        if (done) begin
            st_d.ena = 1'b0;
            st_d.dis = 1'b0;
            st_d.irq = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ena_o = st_q.ena;
    assign dis_o = st_q.dis;
    assign nak_o = st_q.nak;
    assign irq_o = st_q.irq;

    assert_dis_complete_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.dis && gnak_eff_i) |=> (!st_q.ena && !st_q.dis && st_q.irq));
    assert_dis_pending_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.dis && !gnak_eff_i) |=> (st_q.dis && st_q.ena));
    assert_dis_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_set_i && !st_q.ena && !st_q.dis) |=> (st_q.irq && !st_q.dis));
    assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.irq && !irq_clr_i) |=> st_q.irq);

endmodule

// File: rtl/out_ep_disable_ctrl.sv
module out_ep_disable_ctrl
    import out_ep_pkg::*;
#(
    parameter int NUM_EP = 4,
    localparam int EPW = (NUM_EP > 1) ? $clog2(NUM_EP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              gnak_set_i,
    input  logic              gnak_clr_i,
    input  logic [NUM_EP-1:0] ep_ena_set_i,
    input  logic [NUM_EP-1:0] ep_dis_set_i,
    input  logic [NUM_EP-1:0] ep_snak_i,
    input  logic [NUM_EP-1:0] ep_cnak_i,
    input  logic              irq_gnak_clr_i,
    input  logic [NUM_EP-1:0] irq_epdis_clr_i,
    input  logic              pkt_start_i,
    input  logic [EPW-1:0]    pkt_ep_i,
    input  logic              pkt_end_i,
    output logic              gnak_req_o,
    output logic              gnak_eff_o,
    output logic              irq_gnak_o,
    output logic [NUM_EP-1:0] ep_ena_o,
    output logic [NUM_EP-1:0] ep_dis_o,
    output logic [NUM_EP-1:0] ep_nak_o,
    output logic [NUM_EP-1:0] irq_epdis_o,
    output logic              resp_valid_o,
    output logic              resp_nak_o,
    output logic              fifo_wr_o
);

    rx_state_t rx_d, rx_q;
    logic      gnak_req, gnak_eff;
    logic      ep_ready;

    gnak_ctrl u_gnak (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (gnak_set_i),
        .clr_i     (gnak_clr_i),
        .irq_clr_i (irq_gnak_clr_i),
        .in_pkt_i  (rx_q.in_pkt),
        .req_o     (gnak_req),
        .eff_o     (gnak_eff),
        .irq_o     (irq_gnak_o)
    );

    for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
        ep_slot u_ep (
            .clk        (clk),
            .rst_n      (rst_n),
            .ena_set_i  (ep_ena_set_i[g]),
            .dis_set_i  (ep_dis_set_i[g]),
            .snak_i     (ep_snak_i[g]),
            .cnak_i     (ep_cnak_i[g]),
            .irq_clr_i  (irq_epdis_clr_i[g]),
            .gnak_eff_i (gnak_eff),
            .ena_o      (ep_ena_o[g]),
            .dis_o      (ep_dis_o[g]),
            .nak_o      (ep_nak_o[g]),
            .irq_o      (irq_epdis_o[g])
        );
    end

    always_comb begin
        ep_ready = 1'b0;
        if (int'(pkt_ep_i) < NUM_EP)
            ep_ready = ep_ena_o[pkt_ep_i] && !ep_nak_o[pkt_ep_i];
    end

    always_comb begin
        rx_d            = rx_q;
        rx_d.resp_valid = pkt_start_i;
        rx_d.resp_nak   = 1'b0;
        rx_d.fifo_wr    = 1'b0;
        if (pkt_end_i) rx_d.in_pkt = 1'b0;
        if (pkt_start_i) begin
            if (!gnak_req && !gnak_eff && !rx_q.in_pkt && ep_ready) begin
                rx_d.fifo_wr = 1'b1;
                rx_d.in_pkt  = 1'b1;
            end else begin
                rx_d.resp_nak = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign gnak_req_o   = gnak_req;
    assign gnak_eff_o   = gnak_eff;
    assign resp_valid_o = rx_q.resp_valid;
    assign resp_nak_o   = rx_q.resp_nak;
    assign fifo_wr_o    = rx_q.fifo_wr;

    assert_nak_under_gnak_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_start_i && (gnak_req || gnak_eff)) |=> (resp_nak_o && !fifo_wr_o));
    assert_resp_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid_o |-> (resp_nak_o != fifo_wr_o));
    assert_fifo_needs_resp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_wr_o || resp_nak_o) |-> resp_valid_o);

endmodule

// File: tb/out_ep_disable_ctrl_tb.sv
module out_ep_disable_ctrl_tb_top;

    localparam int NEP = 4;
    localparam int EW  = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           gnak_set, gnak_clr, irq_gnak_clr, pkt_start, pkt_end;
    logic [NEP-1:0] ena_set, dis_set, snak, cnak, irq_epdis_clr;
    logic [EW-1:0]  pkt_ep;
    logic           gnak_req, gnak_eff, irq_gnak, resp_valid, resp_nak, fifo_wr;
    logic [NEP-1:0] ep_ena, ep_dis, ep_nak, irq_epdis;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    out_ep_disable_ctrl #(.NUM_EP(NEP)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .gnak_set_i(gnak_set), .gnak_clr_i(gnak_clr),
        .ep_ena_set_i(ena_set), .ep_dis_set_i(dis_set),
        .ep_snak_i(snak), .ep_cnak_i(cnak),
        .irq_gnak_clr_i(irq_gnak_clr), .irq_epdis_clr_i(irq_epdis_clr),
        .pkt_start_i(pkt_start), .pkt_ep_i(pkt_ep), .pkt_end_i(pkt_end),
        .gnak_req_o(gnak_req), .gnak_eff_o(gnak_eff), .irq_gnak_o(irq_gnak),
        .ep_ena_o(ep_ena), .ep_dis_o(ep_dis), .ep_nak_o(ep_nak),
        .irq_epdis_o(irq_epdis),
        .resp_valid_o(resp_valid), .resp_nak_o(resp_nak), .fifo_wr_o(fifo_wr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        gnak_set = 0; gnak_clr = 0; irq_gnak_clr = 0; pkt_start = 0; pkt_end = 0;
        ena_set = '0; dis_set = '0; snak = '0; cnak = '0; irq_epdis_clr = '0;
        pkt_ep = '0;
    endtask

    task automatic step();
        @(negedge clk);
        idle_inputs();
    endtask

    // send a packet start and return the response seen one cycle later
    task automatic send_pkt(input int ep, output logic nak, output logic wr, output logic vld);
        pkt_start = 1; pkt_ep = EW'(ep);
        step();
        nak = resp_nak; wr = fifo_wr; vld = resp_valid;
    endtask

    task automatic t_reset();
        chk("R1 ena", {28'd0, ep_ena}, 0);
        chk("R1 dis", {28'd0, ep_dis}, 0);
        chk("R1 nak", {28'd0, ep_nak}, 0);
        chk("R1 irq_ep", {28'd0, irq_epdis}, 0);
        chk("R1 gnak", {29'd0, gnak_req, gnak_eff, irq_gnak}, 0);
        chk("R1 resp", {31'd0, resp_valid}, 0);
    endtask

    task automatic t_accept();
        logic n, w, v;
        ena_set = 4'b0011; step();
        chk("R8 ena", {28'd0, ep_ena}, 32'h3);
        send_pkt(0, n, w, v);
        chk("R8 accept valid", v, 1); chk("R8 accept nak", n, 0); chk("R8 accept wr", w, 1);
        pkt_end = 1; step();
        send_pkt(2, n, w, v);
        chk("R8 not enabled nak", n, 1); chk("R8 not enabled wr", w, 0);
        snak = 4'b0010; step();
        chk("R8 snak", ep_nak[1], 1);
        send_pkt(1, n, w, v);
        chk("R8 nak ep", n, 1);
        cnak = 4'b0010; step();
        chk("R8 cnak", ep_nak[1], 0);
        send_pkt(1, n, w, v);
        chk("R8 after cnak wr", w, 1);
        pkt_end = 1; step();
    endtask

    task automatic t_gnak_wait();
        logic n, w, v;
        send_pkt(0, n, w, v);
        chk("R2 pkt accepted", w, 1);
        gnak_set = 1; step();
        chk("R2 req", gnak_req, 1);
        step(); step();
        chk("R2 held while in flight", gnak_eff, 0);
        pkt_end = 1; step();
        chk("R2 not yet", gnak_eff, 0);
        step();
        chk("R2 effective", gnak_eff, 1);
        chk("R4 irq raised", irq_gnak, 1);
        step();
        chk("R4 sticky", irq_gnak, 1);
        irq_gnak_clr = 1; step();
        chk("R4 w1c", irq_gnak, 0);
        send_pkt(1, n, w, v);
        chk("R5 nak", n, 1); chk("R5 no fifo", w, 0);
        gnak_clr = 1; step();
        chk("R9 eff drop", gnak_eff, 0);
    endtask

    task automatic t_gnak_idle_collide();
        logic n, w, v;
        gnak_set = 1; step();
        chk("R3 one edge", gnak_eff, 0);
        send_pkt(0, n, w, v); // during request only, also the edge where eff rises
        chk("R5 nak during req", n, 1);
        chk("R3 two edges", gnak_eff, 1);
        irq_gnak_clr = 1; step();
        chk("R4 lone clear", irq_gnak, 0);
        gnak_clr = 1; step();
        gnak_set = 1; step();
        irq_gnak_clr = 1; step(); // eff rises at this edge together with clear
        chk("R4 set wins eff", gnak_eff, 1);
        chk("R4 set wins", irq_gnak, 1);
    endtask

    task automatic t_disable();
        // global NAK still effective from previous task; ep1 pending case first
        gnak_clr = 1; step();
        dis_set = 4'b0010; snak = 4'b0010; step();
        step(); step();
        chk("R6 pending dis", ep_dis[1], 1);
        chk("R6 pending ena", ep_ena[1], 1);
        chk("R6 no irq yet", irq_epdis[1], 0);
        gnak_set = 1; step(); step();
        chk("R6 eff", gnak_eff, 1);
        step();
        chk("R6 ena cleared", ep_ena[1], 0);
        chk("R6 dis cleared", ep_dis[1], 0);
        chk("R6 irq", irq_epdis[1], 1);
        chk("R6 ep0 untouched", ep_ena[0], 1);
    endtask

    task automatic t_dis_idle_w1c();
        dis_set = 4'b1000; step();
        chk("R7 dis never set", ep_dis[3], 0);
        chk("R7 irq", irq_epdis[3], 1);
        irq_epdis_clr = 4'b1000; step();
        chk("R10 w1c", irq_epdis[3], 0);
        chk("R10 other bit kept", irq_epdis[1], 1);
        dis_set = 4'b0100; irq_epdis_clr = 4'b0100; step();
        chk("R10 set wins", irq_epdis[2], 1);
    endtask

    task automatic t_resume();
        logic n, w, v;
        gnak_clr = 1; step();
        chk("R9 eff off", gnak_eff, 0);
        send_pkt(0, n, w, v);
        chk("R9 ep0 resumes", w, 1);
        pkt_end = 1; step();
        send_pkt(1, n, w, v);
        chk("R9 disabled ep1 nak", n, 1);
    endtask

    initial begin
        idle_inputs();
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        step();
        t_accept();
        t_gnak_wait();
        t_gnak_idle_collide();
        t_disable();
        t_dis_idle_w1c();
        t_resume();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule